// File: doc/BRIEF.md
# Mode-gated port-function control register

This block holds the few control bits that decide what a small group of port pins does: plain general-purpose I/O, or a bus-control role. The roles covered are two instruction-queue status pins, the external bus-clock pin and the low-byte write strobe pin. The operating mode is captured while reset is held. It is either normal or special, and one of single-chip, expanded-narrow, expanded-wide or peripheral. Each bit follows its own write rule, and the mode chooses that rule. A write the rule forbids is dropped silently.

The stored bits are combined with the captured mode and a few side inputs (clock-test enable, clock-stretch setting, debug-tag enable) to give per-pin function selects and direction controls. The block also produces a one-cycle low-byte tag qualifier for debug tagging. The pad drivers, the instruction queue and the debug engine are outside this block.

Register layout: bit 0 is the queue-status enable, bit 1 is the clock-pin disable, bit 2 is the strobe enable, and the remaining bits read as zero. Mode kind encoding: 0 single-chip, 1 expanded-narrow, 2 expanded-wide, 3 peripheral. Queue-pin function encoding: 0 I/O, 1 bus role, 2 clock-test output.

Top module: `pinfn_ctl`

## Requirements
- R1: After reset, the queue-status and strobe enables read 0. The clock-pin disable reads 1 in single-chip modes and 0 in all other modes.
- R2: In normal modes the first write to the queue-status or strobe enable takes effect, and every later write to that bit is ignored until the next reset.
- R3: In special modes the first write to the queue-status or strobe enable is ignored, and every later write takes effect.
- R4: The clock-pin disable takes only its first write in normal single-chip mode and takes every write in special single-chip mode. In all other modes writes to it are ignored.
- R5: Both queue pins report function 1 when the queue-status enable is set and the mode is expanded-narrow or expanded-wide. Otherwise they report something other than 1.
- R6: With the queue-status enable clear and clock-test enable high, the upper queue pin reports function 2 while the lower one reports 0.
- R7: The clock pin carries the bus clock (clk_pin_fn = 1) when the disable bit is clear, unless the mode is single-chip and estretch is high. In every other case it is I/O (0).
- R8: When the clock pin carries the bus clock it is an output (clk_pin_oe = 1) in every mode except peripheral, where it is an input (0).
- R9: strb_fn is 1 only when the strobe enable is set and the mode is neither single-chip nor normal expanded-narrow.
- R10: In normal expanded-narrow mode, strb_force_hi is high while reset is held and stays high after reset until the first register write.
- R11: In special expanded modes, with the strobe enable set and tag_en high, a cycle with eclk_fall high and strb_pin_in low raises tag_lo for exactly the following cycle. In every other case tag_lo stays low.
- R12: Register bits above bit 2 always read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; mode is captured while it is high |
| mode_special | input | 1 | 1 = special mode, 0 = normal |
| mode_kind | input | 2 | 0 single-chip, 1 expanded-narrow, 2 expanded-wide, 3 peripheral |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Read data: bit0 queue-status enable, bit1 clock-pin disable, bit2 strobe enable |
| clk_test_en | input | 1 | Clock-module test output enable |
| estretch | input | 1 | Clock-stretch setting; high suppresses the bus clock in single-chip modes |
| tag_en | input | 1 | Debug tagging enabled |
| eclk_fall | input | 1 | One-cycle marker of a bus-clock falling edge |
| strb_pin_in | input | 1 | Sampled state of the strobe pin |
| qs_lo_fn | output | 2 | Lower queue pin function: 0 I/O, 1 queue status |
| qs_hi_fn | output | 2 | Upper queue pin function: 0 I/O, 1 queue status, 2 clock test |
| clk_pin_fn | output | 1 | 1 = clock pin carries the bus clock |
| clk_pin_oe | output | 1 | 1 = clock pin driven as an output |
| strb_fn | output | 1 | 1 = strobe pin carries the low-byte strobe |
| strb_force_hi | output | 1 | 1 = strobe pin forced to an output driving high |
| tag_lo | output | 1 | Low-byte instruction tag qualifier |

## Verification
The write rules are exercised with a sequence of a first write followed by later writes, in normal and special flavours of each mode kind. This separates the take-first rule, the skip-first rule, the always rule and the never rule. Pin selects are checked with the same stored bits under expanded, single-chip and peripheral modes, which shows whether the mode gating, rather than the bit alone, picks the function. The tag is driven with the strobe pin low and then high, and in normal and special modes, so a qualifier that ignores the pin level or the mode is caught.

// File: rtl/pinfn_pkg.sv
package pinfn_pkg;

    localparam int CTL_BITS  = 3;
    localparam int BIT_QS    = 0;
    localparam int BIT_NOCLK = 1;
    localparam int BIT_STRB  = 2;

    typedef enum logic [1:0] {
        MK_SINGLE = 2'd0,
        MK_NARROW = 2'd1,
        MK_WIDE   = 2'd2,
        MK_PERIPH = 2'd3
    } mode_kind_e;

    typedef struct packed {
        logic       special;
        mode_kind_e kind;
    } mode_t;

    typedef enum logic [1:0] {
        POL_ONCE        = 2'd0,
        POL_AFTER_FIRST = 2'd1,
        POL_ANY         = 2'd2,
        POL_NEVER       = 2'd3
    } wpol_e;

    typedef enum logic [1:0] {
        FN_GPIO = 2'd0,
        FN_BUS  = 2'd1,
        FN_TEST = 2'd2
    } pin_fn_e;

    function automatic logic is_expanded(mode_t m);
        return (m.kind == MK_NARROW) || (m.kind == MK_WIDE);
    endfunction

    function automatic logic is_single(mode_t m);
        return m.kind == MK_SINGLE;
    endfunction

    function automatic logic is_normal_narrow(mode_t m);
        return !m.special && (m.kind == MK_NARROW);
    endfunction

    function automatic wpol_e bit_policy(int idx, mode_t m);
        wpol_e p;
        if (idx == BIT_NOCLK) begin
            if (is_single(m)) p = m.special ? POL_ANY : POL_ONCE;
            else              p = POL_NEVER;
        end else begin
            p = m.special ? POL_AFTER_FIRST : POL_ONCE;
        end
        return p;
    endfunction

    function automatic logic bit_reset(int idx, mode_t m);
        return (idx == BIT_NOCLK) && is_single(m);
    endfunction

endpackage

// File: rtl/pinfn_wbit.sv
module pinfn_wbit
    import pinfn_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  rst_val,
    input  wpol_e pol,
    input  logic  wr,
    input  logic  d,
    output logic  q,
    output logic  done
);

    logic accept;

    always_comb begin
        unique case (pol)
            POL_ONCE:        accept = !done;
            POL_AFTER_FIRST: accept = done;
            POL_ANY:         accept = 1'b1;
            default:         accept = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q    <= rst_val;
            done <= 1'b0;
        end else if (wr) begin
            if (accept) q <= d;
            done <= 1'b1;
        end
    end

endmodule

// File: rtl/pinfn_mux.sv
module pinfn_mux
    import pinfn_pkg::*;
(
    input  logic                rst,
    input  mode_t               mode_q,
    input  mode_t               mode_raw,
    input  logic [CTL_BITS-1:0] ctl,
    input  logic                strb_done,
    input  logic                clk_test_en,
    input  logic                estretch,
    output pin_fn_e             qs_lo,
    output pin_fn_e             qs_hi,
    output logic                clk_fn,
    output logic                clk_oe,
    output logic                strb_fn,
    output logic                force_hi
);

    logic qs_live;

    always_comb begin
        qs_live = ctl[BIT_QS] && is_expanded(mode_q);
        qs_lo   = qs_live ? FN_BUS : FN_GPIO;
        if (qs_live)
            qs_hi = FN_BUS;
        else if (!ctl[BIT_QS] && clk_test_en)
            qs_hi = FN_TEST;
        else
            qs_hi = FN_GPIO;

        clk_fn  = !ctl[BIT_NOCLK] && !(is_single(mode_q) && estretch);
        clk_oe  = clk_fn && (mode_q.kind != MK_PERIPH);

        strb_fn = ctl[BIT_STRB] && !is_single(mode_q) && !is_normal_narrow(mode_q);

        if (rst) force_hi = is_normal_narrow(mode_raw);
        else     force_hi = is_normal_narrow(mode_q) && !strb_done;
    end

endmodule

// File: rtl/pinfn_tag.sv
module pinfn_tag
    import pinfn_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  mode_t mode_q,
    input  logic  strb_en,
    input  logic  tag_en,
    input  logic  eclk_fall,
    input  logic  strb_pin_in,
    output logic  tag_lo
);

    logic armed;

    always_comb begin
        armed = mode_q.special && is_expanded(mode_q) && strb_en && tag_en;
    end

    always_ff @(posedge clk) begin
        if (rst) tag_lo <= 1'b0;
        else     tag_lo <= armed && eclk_fall && !strb_pin_in;
    end

endmodule

// File: rtl/pinfn_ctl.sv
module pinfn_ctl
    import pinfn_pkg::*;
#(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_special,
    input  logic [1:0]       mode_kind,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             clk_test_en,
    input  logic             estretch,
    input  logic             tag_en,
    input  logic             eclk_fall,
    input  logic             strb_pin_in,
    output logic [1:0]       qs_lo_fn,
    output logic [1:0]       qs_hi_fn,
    output logic             clk_pin_fn,
    output logic             clk_pin_oe,
    output logic             strb_fn,
    output logic             strb_force_hi,
    output logic             tag_lo
);

    localparam int PAD_W = REG_W - CTL_BITS;

    mode_t               mode_raw;
    mode_t               mode_q;
    logic [CTL_BITS-1:0] ctl;
    logic [CTL_BITS-1:0] done;
    pin_fn_e             qs_lo;
    pin_fn_e             qs_hi;
    logic                unused_wr_hi;

    assign mode_raw     = '{special: mode_special, kind: mode_kind_e'(mode_kind)};
    assign unused_wr_hi = ^reg_wdata[REG_W-1:CTL_BITS];

    always_ff @(posedge clk) begin
        if (rst) mode_q <= mode_raw;
    end

    for (genvar i = 0; i < CTL_BITS; i++) begin : g_bit
        pinfn_wbit i_wbit (
            .clk     (clk),
            .rst     (rst),
            .rst_val (bit_reset(i, mode_raw)),
            .pol     (bit_policy(i, mode_q)),
            .wr      (reg_wr),
            .d       (reg_wdata[i]),
            .q       (ctl[i]),
            .done    (done[i])
        );
    end

    assign reg_rdata = {{PAD_W{1'b0}}, ctl};

    pinfn_mux i_mux (
        .rst         (rst),
        .mode_q      (mode_q),
        .mode_raw    (mode_raw),
        .ctl         (ctl),
        .strb_done   (done[BIT_STRB]),
        .clk_test_en (clk_test_en),
        .estretch    (estretch),
        .qs_lo       (qs_lo),
        .qs_hi       (qs_hi),
        .clk_fn      (clk_pin_fn),
        .clk_oe      (clk_pin_oe),
        .strb_fn     (strb_fn),
        .force_hi    (strb_force_hi)
    );

    assign qs_lo_fn = qs_lo;
    assign qs_hi_fn = qs_hi;

    pinfn_tag i_tag (
        .clk         (clk),
        .rst         (rst),
        .mode_q      (mode_q),
        .strb_en     (ctl[BIT_STRB]),
        .tag_en      (tag_en),
        .eclk_fall   (eclk_fall),
        .strb_pin_in (strb_pin_in),
        .tag_lo      (tag_lo)
    );

endmodule

// File: rtl/pinfn_ctl_chk.sv
module pinfn_ctl_chk
    import pinfn_pkg::*;
#(
    parameter int REG_W = 8
) (
    input logic             clk,
    input logic             rst,
    input mode_t            mode_q,
    input logic             reg_wr,
    input logic [REG_W-1:0] reg_rdata,
    input logic             eclk_fall,
    input logic             strb_pin_in,
    input logic [1:0]       qs_lo_fn,
    input logic [1:0]       qs_hi_fn,
    input logic             clk_pin_fn,
    input logic             clk_pin_oe,
    input logic             strb_fn,
    input logic             strb_force_hi,
    input logic             tag_lo
);

    // R2: a set enable cannot be cleared again in normal modes
    p_qs_sticky_r2: assert property (@(posedge clk) disable iff (rst)
        (!mode_q.special && reg_rdata[BIT_QS]) |=> reg_rdata[BIT_QS]);

    p_strb_sticky_r2: assert property (@(posedge clk) disable iff (rst)
        (!mode_q.special && reg_rdata[BIT_STRB]) |=> reg_rdata[BIT_STRB]);

    // R4: outside single-chip modes the clock-pin disable never changes
    p_noclk_frozen_r4: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && mode_q.kind != MK_SINGLE) |=> $stable(reg_rdata[BIT_NOCLK]));

    // R5
    p_qs_gated_r5: assert property (@(posedge clk) disable iff (rst)
        (qs_lo_fn == FN_BUS) |-> (reg_rdata[BIT_QS] && is_expanded(mode_q)));

    // R6
    p_test_qs_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (qs_hi_fn == FN_TEST) |-> (!reg_rdata[BIT_QS] && qs_lo_fn == FN_GPIO));

    // R8
    p_clk_oe_r8: assert property (@(posedge clk) disable iff (rst)
        clk_pin_oe |-> (clk_pin_fn && mode_q.kind != MK_PERIPH));

    // R9
    p_strb_gated_r9: assert property (@(posedge clk) disable iff (rst)
        strb_fn |-> (reg_rdata[BIT_STRB] && !is_single(mode_q)));

    // R10
    p_force_excl_r10: assert property (@(posedge clk) disable iff (rst)
        strb_force_hi |-> !strb_fn);

    // R11
    p_tag_cause_r11: assert property (@(posedge clk) disable iff (rst)
        tag_lo |-> ($past(eclk_fall) && !$past(strb_pin_in)));

    // R12
    p_pad_zero_r12: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[REG_W-1:CTL_BITS] == '0);

endmodule

bind pinfn_ctl pinfn_ctl_chk #(.REG_W(REG_W)) i_chk (
    .clk           (clk),
    .rst           (rst),
    .mode_q        (mode_q),
    .reg_wr        (reg_wr),
    .reg_rdata     (reg_rdata),
    .eclk_fall     (eclk_fall),
    .strb_pin_in   (strb_pin_in),
    .qs_lo_fn      (qs_lo_fn),
    .qs_hi_fn      (qs_hi_fn),
    .clk_pin_fn    (clk_pin_fn),
    .clk_pin_oe    (clk_pin_oe),
    .strb_fn       (strb_fn),
    .strb_force_hi (strb_force_hi),
    .tag_lo        (tag_lo)
);

// File: tb/test_pinfn_ctl.sv
`timescale 1ns/1ps
module test_pinfn_ctl;

    localparam int REG_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             mode_special = 1'b0;
    logic [1:0]       mode_kind = 2'd2;
    logic             reg_wr = 1'b0;
    logic [REG_W-1:0] reg_wdata = '0;
    logic [REG_W-1:0] reg_rdata;
    logic             clk_test_en = 1'b0;
    logic             estretch = 1'b0;
    logic             tag_en = 1'b0;
    logic             eclk_fall = 1'b0;
    logic             strb_pin_in = 1'b1;
    logic [1:0]       qs_lo_fn, qs_hi_fn;
    logic             clk_pin_fn, clk_pin_oe, strb_fn, strb_force_hi, tag_lo;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    pinfn_ctl #(.REG_W(REG_W)) i_pinfn_ctl (
        .clk(clk), .rst(rst), .mode_special(mode_special), .mode_kind(mode_kind),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .clk_test_en(clk_test_en), .estretch(estretch), .tag_en(tag_en),
        .eclk_fall(eclk_fall), .strb_pin_in(strb_pin_in),
        .qs_lo_fn(qs_lo_fn), .qs_hi_fn(qs_hi_fn), .clk_pin_fn(clk_pin_fn),
        .clk_pin_oe(clk_pin_oe), .strb_fn(strb_fn), .strb_force_hi(strb_force_hi),
        .tag_lo(tag_lo)
    );

    task automatic check(string req, int actual, int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, actual, expected);
        end
    endtask

    task automatic start(bit special, bit [1:0] kind);
        @(negedge clk);
        rst = 1'b1; mode_special = special; mode_kind = kind; reg_wr = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic write(bit [REG_W-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic t_reset();
        start(1'b0, 2'd0);
        check("R1 single rdata", reg_rdata, 2);
        start(1'b1, 2'd2);
        check("R1 wide rdata", reg_rdata, 0);
        start(1'b0, 2'd3);
        check("R1 periph rdata", reg_rdata, 0);
    endtask

    task automatic t_normal_policy();
        start(1'b0, 2'd2);
        write(8'hFF);
        check("R2 first write", reg_rdata, 5);
        check("R12 upper bits", reg_rdata[REG_W-1:3], 0);
        write(8'h00);
        check("R2 later write ignored", reg_rdata, 5);
        check("R4 never in wide", reg_rdata[1], 0);
    endtask

    task automatic t_special_policy();
        start(1'b1, 2'd2);
        write(8'h05);
        check("R3 first write ignored", reg_rdata, 0);
        write(8'h05);
        check("R3 second write", reg_rdata, 5);
        write(8'h00);
        check("R3 third write", reg_rdata, 0);
    endtask

    task automatic t_noclk();
        start(1'b0, 2'd0);
        write(8'h00);
        check("R4 normal single first", reg_rdata[1], 0);
        write(8'h02);
        check("R4 normal single later", reg_rdata[1], 0);
        start(1'b1, 2'd0);
        write(8'h00);
        check("R4 special single a", reg_rdata[1], 0);
        write(8'h02);
        check("R4 special single b", reg_rdata[1], 1);
        start(1'b1, 2'd1);
        write(8'h02);
        write(8'h02);
        check("R4 never in special narrow", reg_rdata[1], 0);
    endtask

    task automatic t_pins();
        start(1'b0, 2'd2);
        write(8'h05);
        check("R5 lo bus", qs_lo_fn, 1);
        check("R5 hi bus", qs_hi_fn, 1);
        check("R9 strobe wide", strb_fn, 1);
        check("R7 clock wide", clk_pin_fn, 1);
        check("R8 oe wide", clk_pin_oe, 1);
        start(1'b1, 2'd0);
        write(8'h01);
        write(8'h01);
        check("R5 single stays gpio", qs_lo_fn, 0);
        estretch = 1'b1; #1;
        check("R7 single stretch", clk_pin_fn, 0);
        estretch = 1'b0; #1;
        check("R7 single no stretch", clk_pin_fn, 1);
        write(8'h00);
        clk_test_en = 1'b1; #1;
        check("R6 hi test", qs_hi_fn, 2);
        check("R6 lo gpio", qs_lo_fn, 0);
        clk_test_en = 1'b0;
        start(1'b0, 2'd3);
        check("R8 periph fn", clk_pin_fn, 1);
        check("R8 periph input", clk_pin_oe, 0);
        start(1'b0, 2'd2);
        write(8'h02);
        check("R7 wide disable ignored", clk_pin_fn, 1);
    endtask

    task automatic t_narrow();
        @(negedge clk);
        rst = 1'b1; mode_special = 1'b0; mode_kind = 2'd1;
        #1;
        check("R10 during reset", strb_force_hi, 1);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R10 after reset", strb_force_hi, 1);
        write(8'h04);
        check("R10 released", strb_force_hi, 0);
        check("R9 normal narrow no strobe", strb_fn, 0);
        start(1'b1, 2'd1);
        check("R10 special narrow", strb_force_hi, 0);
        write(8'h04);
        write(8'h04);
        check("R9 special narrow strobe", strb_fn, 1);
    endtask

    task automatic pulse_tag(bit pin, int expected, string req);
        @(negedge clk);
        eclk_fall = 1'b1; strb_pin_in = pin;
        @(posedge clk); #1;
        check(req, tag_lo, expected);
        @(negedge clk);
        eclk_fall = 1'b0; strb_pin_in = 1'b1;
        @(posedge clk); #1;
        check("R11 one cycle", tag_lo, 0);
    endtask

    task automatic t_tag();
        tag_en = 1'b1;
        start(1'b1, 2'd2);
        write(8'h04);
        write(8'h04);
        pulse_tag(1'b0, 1, "R11 tag low pin");
        pulse_tag(1'b1, 0, "R11 pin high no tag");
        tag_en = 1'b0;
        pulse_tag(1'b0, 0, "R11 tagging off");
        tag_en = 1'b1;
        start(1'b0, 2'd2);
        write(8'h04);
        pulse_tag(1'b0, 0, "R11 normal mode no tag");
        tag_en = 1'b0;
    endtask

    initial begin
        t_reset();
        t_normal_policy();
        t_special_policy();
        t_noclk();
        t_pins();
        t_narrow();
        t_tag();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule